// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds eight hardware token flags that two independent ports share. Software on either side uses the flags to agree on who owns a shared resource. A port asks for a flag by writing to it, then reads the flag back to find out whether it now holds it. A request made while the other side holds the flag waits inside the block. The flag passes to the waiting side on its own as soon as the holder lets go.

Each port has its own flag-select strobe, a memory-enable input, a write strobe, an output-enable, a 3-bit flag index and 8-bit write and read data. The flag bank is separate from any memory array. An access counts as a flag access only while the memory enable of that port is low. If a port raises both strobes together, that is an illegal cycle and it is ignored. Every write and read is a single-cycle operation with no handshake. Writes take effect at the rising clock edge. Read data is combinational from the current flag state. No data stream passes through the block, so every pin is plain control or status.

Top module: `xport_semaphore`

## Requirements
- R1: There are eight flags, selected by the 3-bit index. An operation on one index leaves the other seven unchanged.
- R2: A flag write looks only at write-data bit 0. Bit 0 = 0 requests the flag and bit 0 = 1 releases it. Bits 7:1 have no effect.
- R3: A flag read drives the flag status on all eight read-data bits. The read gives 8'h00 to the port that holds the flag and 8'hFF otherwise, which includes a port whose request is only pending. In any cycle that is not a flag read, read data is 8'h00.
- R4: An access needs `sem_sel`=1 and `mem_en`=0. A read also needs `oe`=1 and `wr`=0. A write (`wr`=1) ignores `oe`.
- R5: A cycle with `sem_sel`=1 and `mem_en`=1 is illegal. It changes no flag and reads 8'h00.
- R6: A request for a flag that the other port holds stays pending. When the holder releases the flag, ownership passes to the pending port at that same clock edge.
- R7: If both ports request the same free flag in one cycle, the left port gets it and the right port's request stays pending.
- R8: After reset every flag is free and reads 8'hFF from both ports.
- R9: A request from the port that already holds the flag changes nothing. A release from a port that neither holds nor waits for the flag changes nothing. A release from a port that is waiting withdraws its request.
- R10: The two ports work independently: both can operate on different flags, or on the same flag, in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_sel | input | 1 | Left flag-select strobe |
| l_mem_en | input | 1 | Left memory enable (must be 0 for a flag access) |
| l_wr | input | 1 | Left write (1) / read (0) |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data |
| r_sem_sel | input | 1 | Right flag-select strobe |
| r_mem_en | input | 1 | Right memory enable (must be 0 for a flag access) |
| r_wr | input | 1 | Right write (1) / read (0) |
| r_oe | input | 1 | Right output enable for reads |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data |

## Verification
The bench builds the block with its default parameters: eight flags, a 3-bit index and 8-bit data. At that size every flag and every mix of control strobes on both ports can be reached in a few thousand cycles. Directed sequences cover reset, pending requests and hand-over, same-cycle contention, illegal cycles and ignored data bits. After them comes a long pseudo-random sweep of paired port operations. In every cycle the sweep compares both read buses with an arithmetic ownership model kept in the bench.

// File: rtl/xport_sem_pkg.sv
package xport_sem_pkg;
  localparam int unsigned FLAG_COUNT = 8;
  localparam int unsigned DATA_BITS  = 8;

  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;
endpackage

// File: rtl/xport_sem_decode.sv
module xport_sem_decode #(
  parameter int unsigned NUM_FLAGS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                 sem_sel,
  input  logic                 mem_en,
  input  logic                 wr,
  input  logic                 oe,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 wbit0,
  output logic [NUM_FLAGS-1:0] req,
  output logic [NUM_FLAGS-1:0] rel,
  output logic                 rd_en
);
  logic                 acc;
  logic                 wr_acc;
  logic [NUM_FLAGS-1:0] sel_vec;

  always_comb begin
    acc     = sem_sel & ~mem_en;
    wr_acc  = acc & wr;
    rd_en   = acc & ~wr & oe;
    sel_vec = NUM_FLAGS'(1) << idx;
    req     = (wr_acc & ~wbit0) ? sel_vec : '0;
    rel     = (wr_acc &  wbit0) ? sel_vec : '0;
  end
endmodule

// File: rtl/xport_sem_cell.sv
module xport_sem_cell
  import xport_sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic held_l,
  output logic held_r,
  output logic pend_l,
  output logic pend_r
);
  holder_e holder_q, holder_d;
  logic    pend_l_q, pend_r_q;
  logic    want_l, want_r;

  assign held_l = (holder_q == HOLD_LEFT);
  assign held_r = (holder_q == HOLD_RIGHT);
  assign pend_l = pend_l_q;
  assign pend_r = pend_r_q;

  always_comb begin
    want_l = held_l ? ~rel_l : ((pend_l_q | req_l) & ~rel_l);
    want_r = held_r ? ~rel_r : ((pend_r_q | req_r) & ~rel_r);
    if (held_l && want_l)      holder_d = HOLD_LEFT;
    else if (held_r && want_r) holder_d = HOLD_RIGHT;
    else if (want_l)           holder_d = HOLD_LEFT;
    else if (want_r)           holder_d = HOLD_RIGHT;
    else                       holder_d = HOLD_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q <= HOLD_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      holder_q <= holder_d;
      pend_l_q <= want_l & (holder_d != HOLD_LEFT);
      pend_r_q <= want_r & (holder_d != HOLD_RIGHT);
    end
  end

  // R6: at most one holder
  a_r6_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({held_l, held_r}));
  // R9: a holder keeps the flag until it releases it
  a_r9_holder_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    held_l && !rel_l |=> held_l);
  // R6: a waiting port gets the flag when the holder lets go
  a_r6_handover: assert property (@(posedge clk) disable iff (!rst_n)
    held_l && rel_l && pend_r && !rel_r |=> held_r);
  // R7: the left port wins a free flag
  a_r7_left_first: assert property (@(posedge clk) disable iff (!rst_n)
    !held_l && !held_r && req_l && !rel_l |=> held_l);
endmodule

// File: rtl/xport_semaphore.sv
module xport_semaphore
  import xport_sem_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = FLAG_COUNT,
  parameter int unsigned DATA_W    = DATA_BITS,
  localparam int unsigned IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [IDX_W-1:0]  l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [IDX_W-1:0]  r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_FLAGS-1:0] held_l_v, held_r_v, pend_l_v, pend_r_v;
  logic                 l_rd, r_rd;

  xport_sem_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_en(l_mem_en), .wr(l_wr), .oe(l_oe),
    .idx(l_addr), .wbit0(l_wdata[0]),
    .req(l_req), .rel(l_rel), .rd_en(l_rd)
  );

  xport_sem_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_en(r_mem_en), .wr(r_wr), .oe(r_oe),
    .idx(r_addr), .wbit0(r_wdata[0]),
    .req(r_req), .rel(r_rel), .rd_en(r_rd)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    xport_sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(l_req[g]), .rel_l(l_rel[g]),
      .req_r(r_req[g]), .rel_r(r_rel[g]),
      .held_l(held_l_v[g]), .held_r(held_r_v[g]),
      .pend_l(pend_l_v[g]), .pend_r(pend_r_v[g])
    );
  end

  always_comb begin
    l_rdata = l_rd ? {DATA_W{~held_l_v[l_addr]}} : '0;
    r_rdata = r_rd ? {DATA_W{~held_r_v[r_addr]}} : '0;
  end

  // R5: an illegal cycle on one port with no write on the other changes no flag
  a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sem_sel && l_mem_en) && !(r_sem_sel && !r_mem_en && r_wr)
    |=> $stable({held_l_v, held_r_v, pend_l_v, pend_r_v}));
  // R3: read data is always all-zero or all-one
  a_r3_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));
  // R4: no read data without output enable
  a_r4_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !l_oe |-> l_rdata == '0);
  // R6: a port never holds and waits for the same flag
  a_r6_no_self_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ((held_l_v & pend_l_v) == '0) && ((held_r_v & pend_r_v) == '0));
endmodule

// File: tb/xport_semaphore_bench.sv
module xport_semaphore_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_sem_sel = 0, l_mem_en = 0, l_wr = 0, l_oe = 0;
  logic       r_sem_sel = 0, r_mem_en = 0, r_wr = 0, r_oe = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_wdata = 0, r_wdata = 0;
  logic [7:0] l_rdata, r_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  // ownership model: 0 free, 1 left, 2 right
  int mo [8];
  bit mpl [8];
  bit mpr [8];
  int unsigned seed = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  xport_semaphore u_xport_semaphore (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_oe(l_oe),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_oe(r_oe),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // op codes: 0 idle, 1 write, 2 read, 3 illegal write, 4 illegal read,
  // 5 read without oe, 6 memory cycle, 7 write with oe high
  function automatic logic [3:0] ctl(input int op);
    case (op)
      1: return 4'b1010;
      2: return 4'b1001;
      3: return 4'b1110;
      4: return 4'b1101;
      5: return 4'b1000;
      6: return 4'b0101;
      7: return 4'b1011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic bit is_wr(input int op);
    return op == 1 || op == 7;
  endfunction

  function automatic logic [7:0] expect_rd(input int me, input int op, input int a);
    if (op != 2) return 8'h00;
    return (mo[a] == me) ? 8'h00 : 8'hFF;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic model_update(input int lop, input int la, input logic [7:0] lw,
                              input int rop, input int ra, input logic [7:0] rw);
    for (int f = 0; f < 8; f++) begin
      bit qL, xL, qR, xR, wl, wr2;
      int nh;
      qL = is_wr(lop) && la == f && !lw[0];
      xL = is_wr(lop) && la == f &&  lw[0];
      qR = is_wr(rop) && ra == f && !rw[0];
      xR = is_wr(rop) && ra == f &&  rw[0];
      wl  = (mo[f] == 1) ? !xL : ((mpl[f] || qL) && !xL);
      wr2 = (mo[f] == 2) ? !xR : ((mpr[f] || qR) && !xR);
      if (mo[f] == 1 && wl)      nh = 1;
      else if (mo[f] == 2 && wr2) nh = 2;
      else if (wl)               nh = 1;
      else if (wr2)              nh = 2;
      else                       nh = 0;
      mo[f]  = nh;
      mpl[f] = wl && nh != 1;
      mpr[f] = wr2 && nh != 2;
    end
  endtask

  task automatic step(input string tag,
                      input int lop, input int la, input logic [7:0] lw,
                      input int rop, input int ra, input logic [7:0] rw);
    @(negedge clk);
    {l_sem_sel, l_mem_en, l_wr, l_oe} = ctl(lop);
    l_addr = la[2:0]; l_wdata = lw;
    {r_sem_sel, r_mem_en, r_wr, r_oe} = ctl(rop);
    r_addr = ra[2:0]; r_wdata = rw;
    #(CLK_PERIOD/2 - 1);
    check(tag, "left", l_rdata, expect_rd(1, lop, la));
    check(tag, "right", r_rdata, expect_rd(2, rop, ra));
    @(posedge clk);
    model_update(lop, la, lw, rop, ra, rw);
  endtask

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL all-requirements watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 8; f++) begin mo[f] = 0; mpl[f] = 0; mpr[f] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: all flags free after reset, fixed value 8'hFF on both ports
    for (int f = 0; f < 8; f++) begin
      step("R8", 2, f, 8'h00, 2, 7 - f, 8'h00);
      check("R8", "left-fixed", l_rdata, 8'hFF);
    end

    // R2: bits 7:1 high, bit0 = 0 still requests
    step("R2", 1, 3, 8'hFE, 0, 0, 8'h00);
    step("R2", 2, 3, 8'h00, 2, 3, 8'h00);
    check("R2", "left-owner-fixed", l_rdata, 8'h00);
    // R1: other flags untouched
    for (int f = 0; f < 8; f++) step("R1", 2, f, 8'h00, 2, f, 8'h00);
    // R6: right request while left holds -> pending, reads FF
    step("R6", 0, 0, 8'h00, 1, 3, 8'h00);
    step("R6", 0, 0, 8'h00, 2, 3, 8'h00);
    check("R6", "right-pending-fixed", r_rdata, 8'hFF);
    // R9: holder re-request changes nothing
    step("R9", 1, 3, 8'h00, 0, 0, 8'h00);
    step("R9", 2, 3, 8'h00, 2, 3, 8'h00);
    // R2: release with bits 7:1 low, bit0 = 1 -> automatic grant to right (R6)
    step("R2", 1, 3, 8'h01, 0, 0, 8'h00);
    step("R6", 2, 3, 8'h00, 2, 3, 8'h00);
    check("R6", "right-granted-fixed", r_rdata, 8'h00);
    // R5: illegal release by right does nothing
    step("R5", 0, 0, 8'h00, 3, 3, 8'hFF);
    step("R5", 4, 3, 8'h00, 2, 3, 8'h00);
    check("R5", "right-still-owner", r_rdata, 8'h00);
    // R4: memory cycle and oe-less read are not flag operations
    step("R4", 6, 3, 8'h01, 5, 3, 8'h00);
    step("R4", 7, 5, 8'h00, 2, 3, 8'h00);
    step("R4", 2, 5, 8'h00, 1, 3, 8'hFF);
    // R7: simultaneous request of a free flag
    step("R7", 1, 6, 8'h00, 1, 6, 8'h00);
    step("R7", 2, 6, 8'h00, 2, 6, 8'h00);
    check("R7", "left-wins-fixed", l_rdata, 8'h00);
    // R9: pending right withdraws, then left release leaves flag free
    step("R9", 0, 0, 8'h00, 1, 6, 8'h01);
    step("R9", 1, 6, 8'h01, 0, 0, 8'h00);
    step("R9", 2, 6, 8'h00, 2, 6, 8'h00);
    check("R9", "free-fixed", r_rdata, 8'hFF);
    // R10: different flags in the same cycle
    step("R10", 1, 0, 8'h00, 1, 1, 8'h00);
    step("R10", 2, 0, 8'h00, 2, 1, 8'h00);
    check("R10", "right-own-fixed", r_rdata, 8'h00);

    // R3 / R10: pseudo-random sweep of paired operations
    for (int i = 0; i < 4000; i++) begin
      int unsigned a, b;
      a = rnd(); b = rnd();
      step("R3", int'(a % 8), int'((a >> 4) % 8), 8'((a >> 8)),
                 int'(b % 8), int'((b >> 4) % 8), 8'((b >> 8)));
    end
    finish_run();
  end
endmodule